// File: doc/BRIEF.md
# Processor Low-Power Entry Sequencer

This block sits on the chipset side of a processor link and moves the processor into its idle power states. Software requests a state by reading one of two level ports. A read of the level-2 port raises the stop-clock pin, which holds the processor in stop-grant. A read of the level-3 port raises stop-clock first and, after a programmable gap, raises the sleep pin. If deep entry is enabled, a second gap follows and then the external processor clock is gated off.

In sleep the processor cannot see bus traffic or interrupts. The block therefore watches a wake input itself. On wake it undoes the pins in reverse order: clock back on, a gap, sleep low, a gap, stop-clock low. A status port reports the state currently shown on the pins.

The read port is a plain strobe with no back-pressure. Every strobe is accepted, and its data appears on the cycle after it. Pins and status are plain level signals.

Top module: `cpu_sleep_seq`

## Requirements
- R1: A level-2 read (address 4) raises `stpclk_o` on the cycle after the strobe and leaves `slp_o` low (stop-grant).
- R2: A level-3 read (address 5) raises `stpclk_o` on the cycle after the strobe. With `deep_en` low, the block rests in sleep with `stpclk_o` and `slp_o` both high.
- R3: `slp_o` is high only while `stpclk_o` is high, and it rises G cycles after `stpclk_o`. G = `cfg_gap` when that is at least 8, otherwise G = 8. `cfg_gap` is sampled when each wait starts.
- R4: With `deep_en` high at the moment `slp_o` rises, `clk_en_o` drops G cycles later. `clk_en_o` is low only while `slp_o` is high.
- R5: On wake from sleep or deep sleep, `clk_en_o` returns high on the next cycle. `slp_o` drops G cycles after wake and `stpclk_o` drops G cycles after that. On wake from stop-grant, `stpclk_o` drops on the next cycle.
- R6: Read data is registered and appears one cycle after the strobe. Level-port reads and unmapped addresses return all zeros. A read of address 0 returns the status code in bits [1:0]: 0 run, 1 stop-grant, 2 sleep, 3 deep sleep. `pstate_o` shows the same code continuously.
- R7: Level reads during an entry or exit wait, or while in sleep or deep sleep, have no effect. A level-2 read in stop-grant has no effect. A level-3 read in stop-grant starts sleep entry.
- R8: A wake during an entry wait is held. The exit then begins on the cycle after the sleep or deep state is reached. Wake in run or during an exit wait is ignored.
- R9: After reset, `stpclk_o` and `slp_o` are low, `clk_en_o` is high and the status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| cfg_gap | input | GAP_W | Programmed gap between pin steps (floor 8) |
| deep_en | input | 1 | Permit gating the external clock after sleep |
| wake_evt | input | 1 | Wake event |
| stpclk_o | output | 1 | Stop-clock pin to processor |
| slp_o | output | 1 | Sleep pin to processor |
| clk_en_o | output | 1 | External processor clock enable |
| pstate_o | output | 2 | Current power-state code |

## Verification
The hardest case to reach from the ports is a wake that lands inside an entry wait. The wait is at least eight cycles long and is only open after a level-3 read from run or stop-grant. The bench drives a directed case that pulses wake one cycle into the wait. Random traffic also keeps wake rare and level reads frequent, so that entries start often and wakes fall at many offsets into the waits. A cycle model in the bench, built from the requirements, predicts every pin and read value.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [2:0] {
    S_RUN,
    S_C2,
    S_ENT_SLP,
    S_C3,
    S_ENT_DEEP,
    S_C4,
    S_EX_CLK,
    S_EX_SLP
  } seq_state_t;

  localparam logic [1:0] CODE_RUN  = 2'd0;
  localparam logic [1:0] CODE_STOP = 2'd1;
  localparam logic [1:0] CODE_SLP  = 2'd2;
  localparam logic [1:0] CODE_DEEP = 2'd3;

endpackage

// File: rtl/sleep_rd_decode.sv
module sleep_rd_decode #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int STAT_ADDR = 0,
  parameter int LVL2_ADDR = 4,
  parameter int LVL3_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        status_code,
  output logic              lvl2_hit,
  output logic              lvl3_hit,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_LVL2 = ADDR_W'(LVL2_ADDR);
  localparam logic [ADDR_W-1:0] A_LVL3 = ADDR_W'(LVL3_ADDR);

  logic stat_hit;

  assign lvl2_hit = rd_en && (rd_addr == A_LVL2);
  assign lvl3_hit = rd_en && (rd_addr == A_LVL3);
  assign stat_hit = rd_en && (rd_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (stat_hit) rd_data <= {{(DATA_W-2){1'b0}}, status_code};
    else rd_data <= '0;
  end

  AST_LVL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl2_hit || lvl3_hit) |=> (rd_data == '0)); // R6

endmodule

// File: rtl/sleep_gap_timer.sv
module sleep_gap_timer #(
  parameter int GAP_W   = 8,
  parameter int MIN_GAP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] cfg_gap,
  output logic             done
);

  localparam logic [GAP_W-1:0] FLOOR = GAP_W'(MIN_GAP);

  logic [GAP_W-1:0] cnt;
  logic [GAP_W-1:0] eff_gap;

  assign eff_gap = (cfg_gap < FLOOR) ? FLOOR : cfg_gap;
  assign done    = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= eff_gap - 1'b1;
    else if (!done) cnt <= cnt - 1'b1;
  end

  AST_LOAD_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !done); // R3

endmodule

// File: rtl/sleep_pin_fsm.sv
module sleep_pin_fsm
  import sleep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl2_hit,
  input  logic       lvl3_hit,
  input  logic       wake,
  input  logic       deep_en,
  input  logic       tmr_done,
  output logic       tmr_load,
  output logic       stp,
  output logic       slp,
  output logic       clk_en,
  output logic [1:0] code
);

  seq_state_t st, nxt;
  logic stp_n, slp_n, clk_n, pend, pend_n;

  always_comb begin
    nxt      = st;
    stp_n    = stp;
    slp_n    = slp;
    clk_n    = clk_en;
    pend_n   = pend;
    tmr_load = 1'b0;
    case (st)
      S_RUN: begin
        if (lvl2_hit) begin
          nxt = S_C2; stp_n = 1'b1;
        end else if (lvl3_hit) begin
          nxt = S_ENT_SLP; stp_n = 1'b1; tmr_load = 1'b1;
        end
      end
      S_C2: begin
        if (wake) begin
          nxt = S_RUN; stp_n = 1'b0;
        end else if (lvl3_hit) begin
          nxt = S_ENT_SLP; tmr_load = 1'b1;
        end
      end
      S_ENT_SLP: begin
        if (wake) pend_n = 1'b1;
        if (tmr_done) begin
          slp_n = 1'b1;
          if (deep_en) begin
            nxt = S_ENT_DEEP; tmr_load = 1'b1;
          end else begin
            nxt = S_C3;
          end
        end
      end
      S_ENT_DEEP: begin
        if (wake) pend_n = 1'b1;
        if (tmr_done) begin
          nxt = S_C4; clk_n = 1'b0;
        end
      end
      S_C3: begin
        if (wake || pend) begin
          nxt = S_EX_CLK; tmr_load = 1'b1; pend_n = 1'b0;
        end
      end
      S_C4: begin
        if (wake || pend) begin
          nxt = S_EX_CLK; tmr_load = 1'b1; pend_n = 1'b0; clk_n = 1'b1;
        end
      end
      S_EX_CLK: begin
        if (tmr_done) begin
          nxt = S_EX_SLP; slp_n = 1'b0; tmr_load = 1'b1;
        end
      end
      S_EX_SLP: begin
        if (tmr_done) begin
          nxt = S_RUN; stp_n = 1'b0;
        end
      end
      default: nxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_RUN;
      stp    <= 1'b0;
      slp    <= 1'b0;
      clk_en <= 1'b1;
      pend   <= 1'b0;
    end else begin
      st     <= nxt;
      stp    <= stp_n;
      slp    <= slp_n;
      clk_en <= clk_n;
      pend   <= pend_n;
    end
  end

  always_comb begin
    if (!clk_en)  code = CODE_DEEP;
    else if (slp) code = CODE_SLP;
    else if (stp) code = CODE_STOP;
    else          code = CODE_RUN;
  end

  AST_SLP_NEEDS_STP: assert property (@(posedge clk) disable iff (!rst_n)
    slp |-> stp); // R3
  AST_GATE_NEEDS_SLP: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> slp); // R4
  AST_SLP_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slp) |-> $past(stp, 8)); // R3
  AST_CLK_BACK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> slp); // R5
  AST_STP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stp) |-> !$past(slp)); // R5

endmodule

// File: rtl/cpu_sleep_seq.sv
module cpu_sleep_seq #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int GAP_W     = 8,
  parameter int MIN_GAP   = 8,
  parameter int STAT_ADDR = 0,
  parameter int LVL2_ADDR = 4,
  parameter int LVL3_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic              deep_en,
  input  logic              wake_evt,
  output logic              stpclk_o,
  output logic              slp_o,
  output logic              clk_en_o,
  output logic [1:0]        pstate_o
);

  logic lvl2_hit, lvl3_hit, tmr_load, tmr_done;
  logic [1:0] code;

  sleep_rd_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR),
    .LVL2_ADDR(LVL2_ADDR), .LVL3_ADDR(LVL3_ADDR)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .status_code(code), .lvl2_hit(lvl2_hit), .lvl3_hit(lvl3_hit),
    .rd_data(rd_data)
  );

  sleep_gap_timer #(.GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .cfg_gap(cfg_gap),
    .done(tmr_done)
  );

  sleep_pin_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .lvl2_hit(lvl2_hit), .lvl3_hit(lvl3_hit),
    .wake(wake_evt), .deep_en(deep_en), .tmr_done(tmr_done),
    .tmr_load(tmr_load), .stp(stpclk_o), .slp(slp_o), .clk_en(clk_en_o),
    .code(code)
  );

  assign pstate_o = code;

  AST_PSTATE_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate_o == 2'd3) |-> (!clk_en_o && slp_o && stpclk_o)); // R6

endmodule

// File: tb/cpu_sleep_seq_tb.sv
`timescale 1ns/1ps
module cpu_sleep_seq_tb;

  localparam int ST = 0, L2 = 4, L3 = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  cfg_gap = 8'd10;
  logic        deep_en = 1'b0;
  logic        wake_evt = 1'b0;
  logic        stpclk_o, slp_o, clk_en_o;
  logic [1:0]  pstate_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cpu_sleep_seq u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .cfg_gap(cfg_gap), .deep_en(deep_en),
    .wake_evt(wake_evt), .stpclk_o(stpclk_o), .slp_o(slp_o),
    .clk_en_o(clk_en_o), .pstate_o(pstate_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference cycle model built from the requirements
  int m_st, m_cnt;
  bit m_stp, m_slp, m_clk, m_pend;
  int m_rd;

  function automatic int gap_of(int g);
    return (g < 8) ? 8 : g;
  endfunction

  function automatic int code_of(bit s, bit l, bit c);
    return !c ? 3 : l ? 2 : s ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_stp = 0; m_slp = 0; m_clk = 1; m_pend = 0; m_rd = 0;
    end else begin
      bit l2, l3, dn;
      int ncnt;
      l2 = rd_en && rd_addr == L2;
      l3 = rd_en && rd_addr == L3;
      dn = (m_cnt == 0);
      m_rd = (rd_en && rd_addr == ST) ? code_of(m_stp, m_slp, m_clk) : 0;
      ncnt = dn ? 0 : m_cnt - 1;
      case (m_st)
        0: if (l2) begin m_st = 1; m_stp = 1; end
           else if (l3) begin m_st = 2; m_stp = 1; ncnt = gap_of(cfg_gap) - 1; end
        1: if (wake_evt) begin m_st = 0; m_stp = 0; end
           else if (l3) begin m_st = 2; ncnt = gap_of(cfg_gap) - 1; end
        2: begin
             if (wake_evt) m_pend = 1;
             if (dn) begin
               m_slp = 1;
               if (deep_en) begin m_st = 4; ncnt = gap_of(cfg_gap) - 1; end
               else m_st = 3;
             end
           end
        4: begin
             if (wake_evt) m_pend = 1;
             if (dn) begin m_st = 5; m_clk = 0; end
           end
        3, 5: if (wake_evt || m_pend) begin
               m_st = 6; m_pend = 0; m_clk = 1; ncnt = gap_of(cfg_gap) - 1;
             end
        6: if (dn) begin m_st = 7; m_slp = 0; ncnt = gap_of(cfg_gap) - 1; end
        7: if (dn) begin m_st = 0; m_stp = 0; end
        default: m_st = 0;
      endcase
      m_cnt = ncnt;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 stpclk model", stpclk_o, m_stp);
      chk("R3 sleep model", slp_o, m_slp);
      chk("R4 clk_en model", clk_en_o, m_clk);
      chk("R6 status model", pstate_o, code_of(m_stp, m_slp, m_clk));
      chk("R6 rd_data model", rd_data, m_rd);
    end
  end

  task automatic rd(int a);
    rd_addr = 4'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; rd_addr = '0;
  endtask

  task automatic wake_pulse();
    wake_evt = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 stpclk", stpclk_o, 0);
    chk("R9 slp", slp_o, 0);
    chk("R9 clk_en", clk_en_o, 1);
    chk("R9 status", pstate_o, 0);
    // R8 wake in run ignored
    wake_pulse();
    chk("R8 wake in run", stpclk_o, 0);
    // R1 level-2 read
    rd(L2);
    chk("R1 stpclk", stpclk_o, 1);
    chk("R1 slp", slp_o, 0);
    chk("R6 lvl2 data", rd_data, 0);
    // R7 level-2 in stop-grant ignored
    rd(L2);
    chk("R7 lvl2 in C2", pstate_o, 1);
    rd(ST);
    chk("R6 status C2", rd_data, 1);
    // R3 gap clamp: 3 -> 8, level-3 from stop-grant
    cfg_gap = 8'd3; deep_en = 1'b0;
    rd(L3);
    repeat (7) @(negedge clk);
    chk("R3 slp before gap", slp_o, 0);
    @(negedge clk);
    chk("R3 slp at gap", slp_o, 1);
    // R7 level read in sleep ignored
    rd(L2);
    chk("R7 lvl2 in C3", pstate_o, 2);
    rd(ST);
    chk("R6 status C3", rd_data, 2);
    // R5 exit ordering
    wake_pulse();
    repeat (7) @(negedge clk);
    chk("R5 slp held", slp_o, 1);
    @(negedge clk);
    chk("R5 slp drop", slp_o, 0);
    repeat (7) @(negedge clk);
    chk("R5 stp held", stpclk_o, 1);
    @(negedge clk);
    chk("R5 stp drop", stpclk_o, 0);
    // R4 deep sleep with gap 12
    cfg_gap = 8'd12; deep_en = 1'b1;
    rd(L3);
    chk("R2 stp after lvl3", stpclk_o, 1);
    repeat (11) @(negedge clk);
    chk("R2 slp before gap", slp_o, 0);
    @(negedge clk);
    chk("R2 slp after gap", slp_o, 1);
    repeat (11) @(negedge clk);
    chk("R4 clk before gap", clk_en_o, 1);
    @(negedge clk);
    chk("R4 clk gated", clk_en_o, 0);
    rd(ST);
    chk("R6 status deep", rd_data, 3);
    wake_pulse();
    chk("R5 clk restored", clk_en_o, 1);
    repeat (30) @(negedge clk);
    chk("R5 back in run", pstate_o, 0);
    // R8 wake held during entry
    cfg_gap = 8'd8; deep_en = 1'b0;
    rd(L3);
    wake_pulse();
    repeat (6) @(negedge clk);
    chk("R8 slp not yet", slp_o, 0);
    @(negedge clk);
    chk("R8 slp reached", slp_o, 1);
    repeat (8) @(negedge clk);
    chk("R8 slp held in exit", slp_o, 1);
    @(negedge clk);
    chk("R8 slp exit", slp_o, 0);
    repeat (12) @(negedge clk);
    // Random phase
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      rd_en    = (r < 25);
      case ($urandom_range(0, 3))
        0: rd_addr = 4'(ST);
        1: rd_addr = 4'(L2);
        2: rd_addr = 4'(L3);
        default: rd_addr = 4'($urandom_range(0, 15));
      endcase
      wake_evt = ($urandom_range(0, 39) == 0);
      if ($urandom_range(0, 49) == 0) deep_en = ~deep_en;
      if ($urandom_range(0, 99) == 0) cfg_gap = 8'($urandom_range(0, 20));
      @(negedge clk);
    end
    rd_en = 1'b0; wake_evt = 1'b0;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule